// File: doc/BRIEF.md
# Half-Bridge Interlock and Sleep Controller

This block is the digital control core of a half-bridge gate driver. Two synchronous command inputs, one per switch, ask for the high-side and the low-side drive. The block passes each command to its drive output and never lets both drives conduct at once. It also forces safe outputs while the supply is under voltage, and it runs a low-power sleep state. The same two command wires enter and leave that state, so the controller needs no extra pin.

Holding both commands high for a timed interval puts the block to sleep. Holding only the low-side command for the same interval wakes it. A low enable input also forces sleep. That input's rising edges are debounced over a long interval and its falling edges pass through at once. A long undervoltage also forces sleep. In sleep, the high-side driver is released to high impedance and the low-side driver is clamped by a strong pull-down. A bootstrap switch enable tells the charging path when the high-side drive is off. Dead time is left to the external controller.

Top module: `hbridge_guard`

## Requirements
- R1: When both synchronised commands are high, both drive outputs are low, and the two drive outputs are never high in the same cycle.
- R2: A command that rises while the other command owns its drive does not reach its output. When the owning command falls and the other is still high, the other drive turns on.
- R3: With both commands high for SLEEP_CYC consecutive synchronised cycles, the block enters sleep (asleep = 1). A shorter overlap leaves it awake.
- R4: The block leaves sleep only after the high-side command is low and the low-side command is high for SLEEP_CYC consecutive cycles. A break in that pattern restarts the count, and any other pattern keeps the block asleep.
- R5: In sleep, hs_release = 1, ls_pulldown = 1 and both drives are 0.
- R6: In the cycle after uv_flag is seen high, both drives are 0 and ls_pulldown = 1. When the flag clears before its limit, normal driving resumes.
- R7: With uv_flag high for UV_CYC consecutive cycles, the block enters sleep.
- R8: boot_en is 1 exactly while the block is awake and hs_drive is 0. It falls in the same cycle that hs_drive rises.
- R9: Within a few cycles of enable falling, the block is asleep. A rising enable is honoured only after EN_CYC consecutive synchronised high cycles, and a shorter pulse restarts that count.
- R10: After waking, both drives stay low until both commands have been seen low together. A fresh command is then driven.
- R11: After reset, the block is asleep with hs_release = 1, ls_pulldown = 1, boot_en = 0 and both drives 0.
- R12: Commands and enable pass through a two-flop synchroniser. A command change driven before clock edge n reaches its drive output at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd | input | 1 | High-side command |
| ls_cmd | input | 1 | Low-side command |
| uv_flag | input | 1 | Supply undervoltage indication (synchronous by default) |
| enable | input | 1 | Block enable; low forces sleep |
| hs_drive | output | 1 | High-side gate drive |
| ls_drive | output | 1 | Low-side gate drive |
| hs_release | output | 1 | Puts the high-side driver in high impedance |
| ls_pulldown | output | 1 | Engages the strong low-side pull-down |
| boot_en | output | 1 | Turns on the bootstrap charge switch |
| asleep | output | 1 | Sleep status |

## Verification
The assertions treat uv_flag as already synchronous to clk, which holds for the default UV_SYNC = 0. They treat the synchronised commands, rather than the raw pins, as the stimulus that the interlock and interval rules act on. The bench changes every input only on the falling clock edge, so each value is stable over a whole rising edge. It holds each pattern for whole cycles, and it uses short interval parameters so that every timed window, and each break of one, falls inside the run.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   typedef enum logic [1:0] {
      HBG_SLEEP  = 2'd0,
      HBG_REARM  = 2'd1,
      HBG_ACTIVE = 2'd2
   } hbg_state_e;

   typedef struct packed {
      logic hs_drive;
      logic ls_drive;
      logic hs_release;
      logic ls_pulldown;
      logic boot_en;
      logic asleep;
   } hbg_out_s;

   localparam hbg_out_s HBG_OUT_SAFE = '{
      hs_drive:    1'b0,
      ls_drive:    1'b0,
      hs_release:  1'b1,
      ls_pulldown: 1'b1,
      boot_en:     1'b0,
      asleep:      1'b1
   };

   localparam int unsigned HBG_NUM_TIMERS = 4;
   localparam int unsigned HBG_T_SLEEP = 0;
   localparam int unsigned HBG_T_WAKE  = 1;
   localparam int unsigned HBG_T_UV    = 2;
   localparam int unsigned HBG_T_EN    = 3;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbg_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hbg_interval.sv
module hbg_interval #(
   parameter int unsigned LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic done
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("hbg_interval: LIMIT must be at least 1");
   end

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt;

   // Counts consecutive cycles of cond; any gap restarts; saturates at TOP.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!cond) begin
         cnt <= '0;
      end else if (cnt != TOP) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == TOP);

endmodule

// File: rtl/hbg_ctrl_fsm.sv
module hbg_ctrl_fsm
   import hbg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hs_q,
   input  logic ls_q,
   input  logic uv_q,
   input  logic en_ok,
   input  logic slp_done,
   input  logic wake_done,
   input  logic uv_done,
   output logic hs_drive,
   output logic ls_drive,
   output logic hs_release,
   output logic ls_pulldown,
   output logic boot_en,
   output logic asleep
);

   hbg_state_e state_q, state_d;
   hbg_out_s   out_q, out_d;
   logic       go_sleep;
   logic       hs_alone, ls_alone;

   assign hs_alone = hs_q & ~ls_q;
   assign ls_alone = ls_q & ~hs_q;

   always_comb begin
      go_sleep = ~en_ok | slp_done | uv_done;
      state_d  = state_q;
      if (go_sleep) begin
         state_d = HBG_SLEEP;
      end else begin
         unique case (state_q)
            HBG_SLEEP:  if (wake_done && !uv_q)  state_d = HBG_REARM;
            HBG_REARM:  if (!hs_q && !ls_q)      state_d = HBG_ACTIVE;
            HBG_ACTIVE: state_d = HBG_ACTIVE;
            default:    state_d = HBG_SLEEP;
         endcase
      end
   end

   always_comb begin
      out_d.asleep      = (state_d == HBG_SLEEP);
      out_d.hs_drive    = (state_d == HBG_ACTIVE) & ~uv_q & hs_alone;
      out_d.ls_drive    = (state_d == HBG_ACTIVE) & ~uv_q & ls_alone;
      out_d.hs_release  = out_d.asleep;
      out_d.ls_pulldown = out_d.asleep | uv_q;
      out_d.boot_en     = ~out_d.asleep & ~out_d.hs_drive;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HBG_SLEEP;
         out_q   <= HBG_OUT_SAFE;
      end else begin
         state_q <= state_d;
         out_q   <= out_d;
      end
   end

   assign hs_drive    = out_q.hs_drive;
   assign ls_drive    = out_q.ls_drive;
   assign hs_release  = out_q.hs_release;
   assign ls_pulldown = out_q.ls_pulldown;
   assign boot_en     = out_q.boot_en;
   assign asleep      = out_q.asleep;

endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
   import hbg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SLEEP_CYC   = 1000,
   parameter int unsigned UV_CYC      = 1500,
   parameter int unsigned EN_CYC      = 50000,
   parameter bit          UV_SYNC     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_cmd,
   input  logic ls_cmd,
   input  logic uv_flag,
   input  logic enable,
   output logic hs_drive,
   output logic ls_drive,
   output logic hs_release,
   output logic ls_pulldown,
   output logic boot_en,
   output logic asleep
);

   if (SLEEP_CYC < 1 || UV_CYC < 1 || EN_CYC < 1) begin : g_bad_interval
      $error("hbridge_guard: interval parameters must be at least 1");
   end

   localparam int unsigned LIMITS [HBG_NUM_TIMERS] = '{SLEEP_CYC, SLEEP_CYC, UV_CYC, EN_CYC};

   logic [2:0] raw_in, sync_out;
   logic       hs_q, ls_q, en_q, uv_q;
   logic       en_ok, slp_done, wake_done, uv_done;
   logic [HBG_NUM_TIMERS-1:0] t_cond, t_done;

   assign raw_in = {enable, ls_cmd, hs_cmd};

   hbg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_cmd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign hs_q = sync_out[0];
   assign ls_q = sync_out[1];
   assign en_q = sync_out[2];

   if (UV_SYNC) begin : g_uv_sync
      hbg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_uv_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (uv_flag),
         .q     (uv_q)
      );
   end else begin : g_uv_direct
      assign uv_q = uv_flag;
   end

   assign t_cond[HBG_T_SLEEP] = hs_q & ls_q;
   assign t_cond[HBG_T_WAKE]  = ~hs_q & ls_q;
   assign t_cond[HBG_T_UV]    = uv_q;
   assign t_cond[HBG_T_EN]    = en_q;

   for (genvar g = 0; g < HBG_NUM_TIMERS; g++) begin : g_timer
      hbg_interval #(.LIMIT(LIMITS[g])) u_interval (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (t_cond[g]),
         .done  (t_done[g])
      );
   end

   assign slp_done  = t_done[HBG_T_SLEEP];
   assign wake_done = t_done[HBG_T_WAKE];
   assign uv_done   = t_done[HBG_T_UV];
   assign en_ok     = t_done[HBG_T_EN];

   hbg_ctrl_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .hs_q        (hs_q),
      .ls_q        (ls_q),
      .uv_q        (uv_q),
      .en_ok       (en_ok),
      .slp_done    (slp_done),
      .wake_done   (wake_done),
      .uv_done     (uv_done),
      .hs_drive    (hs_drive),
      .ls_drive    (ls_drive),
      .hs_release  (hs_release),
      .ls_pulldown (ls_pulldown),
      .boot_en     (boot_en),
      .asleep      (asleep)
   );

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
   input logic clk,
   input logic rst_n,
   input logic hs_q,
   input logic ls_q,
   input logic uv_q,
   input logic en_ok,
   input logic slp_done,
   input logic uv_done,
   input logic hs_drive,
   input logic ls_drive,
   input logic hs_release,
   input logic ls_pulldown,
   input logic boot_en,
   input logic asleep
);

   a_r1_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_drive && ls_drive));

   a_r1_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q && ls_q) |=> (!hs_drive && !ls_drive));

   a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      slp_done |=> asleep);

   a_r5_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (hs_release && ls_pulldown && !hs_drive && !ls_drive));

   a_r6_uv_force: assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |=> (!hs_drive && !ls_drive && ls_pulldown));

   a_r7_uv_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      uv_done |=> asleep);

   a_r8_boot_off: assert property (@(posedge clk) disable iff (!rst_n)
      boot_en |-> !hs_drive);

   a_r8_boot_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && !hs_drive) |-> boot_en);

   a_r9_enable_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ok |=> asleep);

   a_r10_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> (!hs_drive && !ls_drive));

endmodule

bind hbridge_guard hbg_checker u_hbg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .hs_q        (hs_q),
   .ls_q        (ls_q),
   .uv_q        (uv_q),
   .en_ok       (en_ok),
   .slp_done    (slp_done),
   .uv_done     (uv_done),
   .hs_drive    (hs_drive),
   .ls_drive    (ls_drive),
   .hs_release  (hs_release),
   .ls_pulldown (ls_pulldown),
   .boot_en     (boot_en),
   .asleep      (asleep)
);

// File: tb/hbridge_guard_bench.sv
module hbridge_guard_bench;

   localparam int SLP = 8;
   localparam int UVL = 12;
   localparam int ENL = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_cmd = 1'b0, ls_cmd = 1'b0, uv_flag = 1'b0, enable = 1'b0;
   logic hs_drive, ls_drive, hs_release, ls_pulldown, boot_en, asleep;

   hbridge_guard #(
      .SYNC_STAGES (2),
      .SLEEP_CYC   (SLP),
      .UV_CYC      (UVL),
      .EN_CYC      (ENL),
      .UV_SYNC     (1'b0)
   ) u_hbridge_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .hs_cmd      (hs_cmd),
      .ls_cmd      (ls_cmd),
      .uv_flag     (uv_flag),
      .enable      (enable),
      .hs_drive    (hs_drive),
      .ls_drive    (ls_drive),
      .hs_release  (hs_release),
      .ls_pulldown (ls_pulldown),
      .boot_en     (boot_en),
      .asleep      (asleep)
   );

   always #10 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   string phase  = "R11";
   bit    finished = 1'b0;

   task automatic check(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   // Behavioural reference: pipeline of sampled inputs, run-length counters, mode.
   int m_h[2], m_l[2], m_e[2];
   int run_both, run_wake, run_uv, run_en;
   int mode; // 0 asleep, 1 waiting for quiet inputs, 2 running
   bit e_hd, e_ld, e_rel, e_pd, e_bt, e_sl;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_h = '{0, 0}; m_l = '{0, 0}; m_e = '{0, 0};
         run_both = 0; run_wake = 0; run_uv = 0; run_en = 0;
         mode = 0;
         e_hd = 0; e_ld = 0; e_rel = 1; e_pd = 1; e_bt = 0; e_sl = 1;
      end else begin
         automatic int  nmode;
         automatic bit  sleepy = (run_en < ENL) || (run_both >= SLP) || (run_uv >= UVL);
         if (sleepy)                  nmode = 0;
         else if (mode == 0)          nmode = (run_wake >= SLP && !uv_flag) ? 1 : 0;
         else if (mode == 1)          nmode = (m_h[1] == 0 && m_l[1] == 0) ? 2 : 1;
         else                         nmode = 2;
         e_hd  = (nmode == 2) && !uv_flag && m_h[1] == 1 && m_l[1] == 0;
         e_ld  = (nmode == 2) && !uv_flag && m_l[1] == 1 && m_h[1] == 0;
         e_sl  = (nmode == 0);
         e_rel = e_sl;
         e_pd  = e_sl || uv_flag;
         e_bt  = !e_sl && !e_hd;
         run_both = (m_h[1] == 1 && m_l[1] == 1) ? run_both + 1 : 0;
         run_wake = (m_h[1] == 0 && m_l[1] == 1) ? run_wake + 1 : 0;
         run_uv   = uv_flag ? run_uv + 1 : 0;
         run_en   = (m_e[1] == 1) ? run_en + 1 : 0;
         mode = nmode;
         m_h[1] = m_h[0]; m_h[0] = hs_cmd;
         m_l[1] = m_l[0]; m_l[0] = ls_cmd;
         m_e[1] = m_e[0]; m_e[0] = enable;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(hs_drive,    e_hd,  phase, "hs_drive model R2");
         check(ls_drive,    e_ld,  phase, "ls_drive model R1");
         check(hs_release,  e_rel, phase, "hs_release model R5");
         check(ls_pulldown, e_pd,  phase, "ls_pulldown model R6");
         check(boot_en,     e_bt,  phase, "boot_en model R8");
         check(asleep,      e_sl,  phase, "asleep model R3");
      end
   end

   task automatic hold(input logic h, input logic l, input int n);
      @(negedge clk);
      hs_cmd = h;
      ls_cmd = l;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      phase = "R11";
      check(asleep, 1'b1, "R11", "asleep after reset");
      check(hs_release, 1'b1, "R11", "hs_release after reset");
      check(ls_pulldown, 1'b1, "R11", "ls_pulldown after reset");
      check(boot_en, 1'b0, "R11", "boot_en after reset");
      check(hs_drive | ls_drive, 1'b0, "R11", "drives after reset");

      enable = 1'b1;
      phase = "R9";
      hold(0, 0, 30);
      check(asleep, 1'b1, "R4", "quiet inputs keep sleep");

      phase = "R4";
      hold(0, 1, 5);
      hold(0, 0, 1);
      hold(0, 1, 5);
      check(asleep, 1'b1, "R4", "broken wake pattern restarts count");
      hold(0, 1, 10);
      check(asleep, 1'b0, "R4", "wake after full interval");
      phase = "R10";
      hold(0, 1, 6);
      check(ls_drive, 1'b0, "R10", "stale low command not driven");
      hold(0, 0, 4);
      hold(0, 1, 4);
      check(ls_drive, 1'b1, "R10", "fresh low command driven");
      check(boot_en, 1'b1, "R8", "boot on while high side off");

      phase = "R12";
      hold(0, 0, 4);
      @(negedge clk);
      hs_cmd = 1'b1;
      wait_cyc(2);
      check(hs_drive, 1'b0, "R12", "high drive before third edge");
      wait_cyc(1);
      check(hs_drive, 1'b1, "R12", "high drive at third edge");
      check(boot_en, 1'b0, "R8", "boot off with high drive");

      phase = "R2";
      hold(1, 1, 4);
      check(ls_drive, 1'b0, "R2", "late low command blocked");
      check(hs_drive, 1'b0, "R1", "both commands high");
      hold(1, 0, 4);
      check(hs_drive, 1'b1, "R2", "owner resumes");
      hold(1, 1, 4);
      hold(0, 1, 4);
      check(ls_drive, 1'b1, "R2", "low drive after owner drops");

      phase = "R6";
      hold(1, 0, 4);
      @(negedge clk);
      uv_flag = 1'b1;
      wait_cyc(1);
      check(hs_drive, 1'b0, "R6", "undervoltage forces drive low");
      check(ls_pulldown, 1'b1, "R6", "undervoltage pull-down");
      wait_cyc(2);
      uv_flag = 1'b0;
      wait_cyc(3);
      check(hs_drive, 1'b1, "R6", "drive resumes after short undervoltage");
      check(asleep, 1'b0, "R6", "short undervoltage stays awake");

      phase = "R7";
      @(negedge clk);
      uv_flag = 1'b1;
      wait_cyc(16);
      check(asleep, 1'b1, "R7", "long undervoltage sleeps");
      uv_flag = 1'b0;
      hold(0, 0, 4);
      hold(0, 1, 14);
      check(asleep, 1'b0, "R4", "wake after undervoltage sleep");
      hold(0, 0, 4);

      phase = "R3";
      hold(1, 1, 6);
      check(asleep, 1'b0, "R3", "short overlap stays awake");
      check(hs_drive | ls_drive, 1'b0, "R1", "overlap drives low");
      hold(1, 1, 8);
      check(asleep, 1'b1, "R3", "long overlap sleeps");
      check(hs_release, 1'b1, "R5", "released in sleep");
      check(ls_pulldown, 1'b1, "R5", "pull-down in sleep");
      hold(1, 0, 12);
      check(asleep, 1'b1, "R4", "high-only pattern keeps sleep");
      check(hs_drive, 1'b0, "R5", "no drive in sleep");

      phase = "R9";
      hold(0, 1, 14);
      hold(0, 0, 4);
      check(asleep, 1'b0, "R9", "awake before enable drop");
      @(negedge clk);
      enable = 1'b0;
      wait_cyc(5);
      check(asleep, 1'b1, "R9", "enable drop sleeps quickly");
      enable = 1'b1;
      wait_cyc(10);
      enable = 1'b0;
      wait_cyc(3);
      enable = 1'b1;
      hold(0, 1, 15);
      check(asleep, 1'b1, "R9", "enable debounce restarted");
      hold(0, 1, 14);
      check(asleep, 1'b0, "R9", "wake after debounced enable");
      hold(0, 0, 4);

      finish_run();
   end

endmodule